// File: doc/BRIEF.md
# Quad SPI Instruction Frame Sequencer

This block runs one serial flash instruction frame. It drives a chip select, a serial clock and four IO lines, each line with its own output enable. A one-cycle start pulse captures a setup on the block's inputs: instruction code, option byte, address, phase enables, address length, option length, dummy clock count, line-width mode and transfer type. The frame then passes through the enabled phases in a fixed order (instruction, address, option, dummy, data) and skips any phase that is disabled.

The width mode decides how many IO lines each phase uses. Bytes in the data phase move through byte-wide valid/ready ports, one port for transmit and one for receive. In a frame with a data phase, chip select stays low between bytes until the host issues a last-transfer command. In a frame without one, the frame closes as soon as the last enabled phase ends. In both cases an instruction-end pulse and a chip-select-rise pulse mark the end of the frame.

Top module: `qspi_frame_seq`

## Requirements
- R1: After reset and between frames, cs_n_o is 1, sclk_o is 0, io_oe_o is 0, and tx_ready_o, rx_valid_o, inst_end_o and cs_rise_o are all 0.
- R2: The phases occur in the order instruction, address, option, dummy, data. A phase whose enable is 0 produces no clocks. A dummy count of 0 counts as a disabled dummy phase.
- R3: width_i sets the lines per phase as instruction/address-option/data: 0 is 1/1/1, 1 is 1/1/2, 2 is 1/1/4, 3 is 1/2/2, 4 is 1/4/4, 5 is 2/2/2, 6 is 4/4/4. Code 7 behaves like 0. Bits are sent most significant first. With one line, the bit goes out on IO0 and comes in on IO1. With two lines the order is IO1, IO0. With four lines it is IO3 down to IO0. Only the lines in use are driven.
- R4: The address phase sends addr_i[23:0] when addr32_i is 0 and addr_i[31:0] when it is 1, most significant byte first.
- R5: opt_len_i selects 1, 2, 4 or 8 option bits for codes 0 to 3. The bits are taken from the top of opt_byte_i. The phase lasts bits/lines clocks, and at least one clock.
- R6: The dummy phase lasts dummy_i clocks (0 to 31), and no IO line is driven during it.
- R7: When xfer_type_i[1] is 1 the data phase drives the IO lines from tx bytes. When it is 0 the lines are released, each line is sampled on the sclk rising edge, and every 8 bits form one rx byte. xfer_type_i[0] has no effect on the lines.
- R8: In a frame without data, cs_n_o rises right after the last enabled phase, and a last-transfer command has no effect. If no phase is enabled at all, cs_n_o never falls. inst_end_o and cs_rise_o pulse together for one cycle in the first cycle that cs_n_o is high.
- R9: In a data frame, cs_n_o stays low and sclk_o stays low between bytes. tx_ready_o is high only while the block is waiting for a write byte. rx_valid_o and rx_data_o hold until rx_ready_i is high. last_xfer_i ends the frame at the next byte boundary and takes priority over starting another byte, and the end pulses of R8 follow.
- R10: sclk_o idles low. The IO outputs change only while sclk_o is low. Each high half of sclk_o lasts HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures the setup (idle only) |
| inst_code_i | input | 8 | Instruction code |
| opt_byte_i | input | 8 | Option byte |
| addr_i | input | 32 | Address |
| width_i | input | 3 | Line-width mode |
| inst_en_i | input | 1 | Instruction phase enable |
| addr_en_i | input | 1 | Address phase enable |
| opt_en_i | input | 1 | Option phase enable |
| data_en_i | input | 1 | Data phase enable |
| opt_len_i | input | 2 | Option length code |
| addr32_i | input | 1 | 32-bit address when 1 |
| dummy_i | input | 5 | Dummy clock count |
| xfer_type_i | input | 2 | Transfer type; bit 1 set means write |
| last_xfer_i | input | 1 | Last-transfer command |
| tx_data_i | input | 8 | Write byte |
| tx_valid_i | input | 1 | Write byte valid |
| tx_ready_o | output | 1 | Write byte accepted when valid |
| rx_data_o | output | 8 | Read byte |
| rx_valid_o | output | 1 | Read byte valid |
| rx_ready_i | input | 1 | Read byte taken |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| io_o | output | 4 | IO line output values |
| io_oe_o | output | 4 | IO line output enables |
| io_i | input | 4 | IO line input values |
| inst_end_o | output | 1 | Instruction-end pulse |
| cs_rise_o | output | 1 | Chip-select-rise pulse |

## Verification
A wrong phase pointer or beat counter adds, drops or reorders sclk rising edges. It is seen at the first rising edge whose IO value or enable mask differs from the expected beat list, or when the beat count at the end of the frame is wrong. A wrong lane width shows at the first beat of the affected phase as a wrong output-enable mask. A receive shift error shows when the assembled byte is handed over. A fault in the chip-select hold shows at the next byte gap as cs_n_o high or as stray clocks. A missing or early end shows as an absent end pulse, or as a pulse that arrives with chip select still low.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;
  localparam int NPH = 5;

  typedef enum logic [2:0] {PH_INST, PH_ADDR, PH_OPT, PH_DUM, PH_DATA} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_DWAIT} state_e;

  typedef struct packed {
    logic [2:0]  width;
    logic [NPH-1:0] en;     // bit index = phase_e
    logic [1:0]  opt_len;
    logic        addr32;
    logic [4:0]  dummy;
    logic        wr;
    logic [7:0]  inst;
    logic [7:0]  opt;
    logic [31:0] addr;
  } cfg_t;
endpackage

// File: rtl/qspi_lane_map.sv
module qspi_lane_map (
  input  logic [2:0] width_i,
  output logic [1:0] lg_inst_o,
  output logic [1:0] lg_ao_o,
  output logic [1:0] lg_data_o
);
  // log2 of lines per phase
  always_comb begin
    unique case (width_i)
      3'd1:    {lg_inst_o, lg_ao_o, lg_data_o} = {2'd0, 2'd0, 2'd1};
      3'd2:    {lg_inst_o, lg_ao_o, lg_data_o} = {2'd0, 2'd0, 2'd2};
      3'd3:    {lg_inst_o, lg_ao_o, lg_data_o} = {2'd0, 2'd1, 2'd1};
      3'd4:    {lg_inst_o, lg_ao_o, lg_data_o} = {2'd0, 2'd2, 2'd2};
      3'd5:    {lg_inst_o, lg_ao_o, lg_data_o} = {2'd1, 2'd1, 2'd1};
      3'd6:    {lg_inst_o, lg_ao_o, lg_data_o} = {2'd2, 2'd2, 2'd2};
      default: {lg_inst_o, lg_ao_o, lg_data_o} = {2'd0, 2'd0, 2'd0};
    endcase
  end
endmodule

// File: rtl/qspi_phase_pick.sv
module qspi_phase_pick
  import qspi_seq_pkg::*;
(
  input  logic [NPH-1:0] en_i,
  input  logic [2:0]     from_i,
  input  logic           first_i,
  output logic           found_o,
  output logic [2:0]     ph_o
);
  always_comb begin
    found_o = 1'b0;
    ph_o    = 3'd0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (en_i[i] && (first_i || i > int'(from_i))) begin
        found_o = 1'b1;
        ph_o    = 3'(i);
      end
    end
  end
endmodule

// File: rtl/qspi_sclk_div.sv
module qspi_sclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qspi_frame_seq.sv
module qspi_frame_seq
  import qspi_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  inst_code_i,
  input  logic [7:0]  opt_byte_i,
  input  logic [31:0] addr_i,
  input  logic [2:0]  width_i,
  input  logic        inst_en_i,
  input  logic        addr_en_i,
  input  logic        opt_en_i,
  input  logic        data_en_i,
  input  logic [1:0]  opt_len_i,
  input  logic        addr32_i,
  input  logic [4:0]  dummy_i,
  input  logic [1:0]  xfer_type_i,
  input  logic        last_xfer_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  input  logic        rx_ready_i,
  output logic        cs_n_o,
  output logic        sclk_o,
  output logic [3:0]  io_o,
  output logic [3:0]  io_oe_o,
  input  logic [3:0]  io_i,
  output logic        inst_end_o,
  output logic        cs_rise_o
);
  localparam int SHW = 32;
  localparam int CNTW = $clog2(SHW + 1);

  state_e          state_q;
  phase_e          phase_q;
  cfg_t            cfg_q;
  logic [SHW-1:0]  sh_q;
  logic [CNTW-1:0] cnt_q;
  logic [1:0]      lg_q;
  logic            sclk_q, cs_n_q, end_q, last_q;
  logic [7:0]      rx_q, rx_data_q;
  logic            rx_valid_q;

  logic [1:0] lg_inst, lg_ao, lg_data;
  logic       pick_found, tick;
  logic [2:0] pick_ph;

  qspi_lane_map u_lanes (
    .width_i   (cfg_q.width),
    .lg_inst_o (lg_inst),
    .lg_ao_o   (lg_ao),
    .lg_data_o (lg_data)
  );

  qspi_phase_pick u_pick (
    .en_i    (cfg_q.en),
    .from_i  (phase_q),
    .first_i (state_q == ST_LOAD),
    .found_o (pick_found),
    .ph_o    (pick_ph)
  );

  qspi_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SHIFT),
    .tick_o (tick)
  );

  // load values for the phase about to start
  phase_e          ld_ph;
  logic [SHW-1:0]  ld_sh;
  logic [1:0]      ld_lg;
  logic [CNTW-1:0] ld_bits, ld_beats, ld_cnt;

  always_comb begin
    ld_ph = (state_q == ST_DWAIT) ? PH_DATA : phase_e'(pick_ph);
    unique case (ld_ph)
      PH_INST: begin ld_sh = {cfg_q.inst, 24'h0}; ld_lg = lg_inst; ld_bits = CNTW'(8); end
      PH_ADDR: begin
        ld_sh   = cfg_q.addr32 ? cfg_q.addr : {cfg_q.addr[23:0], 8'h0};
        ld_lg   = lg_ao;
        ld_bits = cfg_q.addr32 ? CNTW'(32) : CNTW'(24);
      end
      PH_OPT:  begin ld_sh = {cfg_q.opt, 24'h0}; ld_lg = lg_ao; ld_bits = CNTW'(1) << cfg_q.opt_len; end
      PH_DUM:  begin ld_sh = '0; ld_lg = 2'd0; ld_bits = CNTW'(cfg_q.dummy); end
      default: begin ld_sh = {tx_data_i, 24'h0}; ld_lg = lg_data; ld_bits = CNTW'(8); end
    endcase
    ld_beats = ld_bits >> ld_lg;
    if (ld_beats == '0) ld_beats = CNTW'(1);
    ld_cnt = ld_beats - 1'b1;
  end

  logic start_rd, start_wr, fin_now;
  assign start_wr   = cfg_q.wr && tx_valid_i;
  assign start_rd   = !cfg_q.wr && !rx_valid_q;
  assign fin_now    = last_q || last_xfer_i;
  assign tx_ready_o = (state_q == ST_DWAIT) && cfg_q.wr && !fin_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_INST;
      cfg_q      <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      lg_q       <= '0;
      sclk_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      end_q      <= 1'b0;
      last_q     <= 1'b0;
      rx_q       <= '0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (rx_valid_q && rx_ready_i) rx_valid_q <= 1'b0;
      if (state_q != ST_IDLE && last_xfer_i && cfg_q.en[PH_DATA]) last_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cfg_q.width   <= width_i;
          cfg_q.en      <= {data_en_i, dummy_i != 5'd0, opt_en_i, addr_en_i, inst_en_i};
          cfg_q.opt_len <= opt_len_i;
          cfg_q.addr32  <= addr32_i;
          cfg_q.dummy   <= dummy_i;
          cfg_q.wr      <= xfer_type_i[1];
          cfg_q.inst    <= inst_code_i;
          cfg_q.opt     <= opt_byte_i;
          cfg_q.addr    <= addr_i;
          last_q        <= 1'b0;
          state_q       <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!pick_found) begin
            end_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cs_n_q  <= 1'b0;
            phase_q <= phase_e'(pick_ph);
            if (phase_e'(pick_ph) == PH_DATA) state_q <= ST_DWAIT;
            else begin
              sh_q <= ld_sh; cnt_q <= ld_cnt; lg_q <= ld_lg;
              state_q <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            if (phase_q == PH_DATA && !cfg_q.wr) begin
              unique case (lg_q)
                2'd0:    rx_q <= {rx_q[6:0], io_i[1]};
                2'd1:    rx_q <= {rx_q[5:0], io_i[1:0]};
                default: rx_q <= {rx_q[3:0], io_i};
              endcase
            end
          end else begin
            sclk_q <= 1'b0;
            if (cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
              unique case (lg_q)
                2'd0:    sh_q <= sh_q << 1;
                2'd1:    sh_q <= sh_q << 2;
                default: sh_q <= sh_q << 4;
              endcase
            end else if (phase_q == PH_DATA) begin
              if (!cfg_q.wr) begin
                rx_data_q  <= rx_q;
                rx_valid_q <= 1'b1;
              end
              state_q <= ST_DWAIT;
            end else if (!pick_found) begin
              cs_n_q  <= 1'b1;
              end_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              phase_q <= phase_e'(pick_ph);
              if (phase_e'(pick_ph) == PH_DATA) state_q <= ST_DWAIT;
              else begin
                sh_q <= ld_sh; cnt_q <= ld_cnt; lg_q <= ld_lg;
              end
            end
          end
        end
        ST_DWAIT: begin
          if (fin_now) begin
            cs_n_q  <= 1'b1;
            end_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (start_wr || start_rd) begin
            sh_q <= ld_sh; cnt_q <= ld_cnt; lg_q <= ld_lg;
            state_q <= ST_SHIFT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic drive;
  always_comb begin
    drive = (state_q == ST_SHIFT) && (phase_q != PH_DUM) &&
            !(phase_q == PH_DATA && !cfg_q.wr);
    unique case (lg_q)
      2'd0:    begin io_o = {3'b000, sh_q[SHW-1]};     io_oe_o = drive ? 4'b0001 : 4'b0000; end
      2'd1:    begin io_o = {2'b00, sh_q[SHW-1 -: 2]}; io_oe_o = drive ? 4'b0011 : 4'b0000; end
      default: begin io_o = sh_q[SHW-1 -: 4];          io_oe_o = drive ? 4'b1111 : 4'b0000; end
    endcase
  end

  assign cs_n_o     = cs_n_q;
  assign sclk_o     = sclk_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign inst_end_o = end_q;
  assign cs_rise_o  = end_q;
endmodule

// File: rtl/qspi_frame_seq_chk.sv
module qspi_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_o,
  input logic       sclk_o,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o,
  input logic       tx_ready_o,
  input logic       rx_valid_o,
  input logic [7:0] rx_data_o,
  input logic       rx_ready_i,
  input logic       inst_end_o,
  input logic       cs_rise_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (!sclk_o && io_oe_o == 4'b0000 && !tx_ready_o));

  // R10
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> ($stable(io_o) && $stable(io_oe_o)));

  // R3
  oe_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o inside {4'b0000, 4'b0001, 4'b0011, 4'b1111});

  // R8
  end_with_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_end_o |-> (cs_n_o && cs_rise_o));

  // R8
  end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inst_end_o |=> !inst_end_o);

  // R9
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R9
  tx_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (!cs_n_o && !sclk_o));
endmodule

bind qspi_frame_seq qspi_frame_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .io_o       (io_o),
  .io_oe_o    (io_oe_o),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .rx_data_o  (rx_data_o),
  .rx_ready_i (rx_ready_i),
  .inst_end_o (inst_end_o),
  .cs_rise_o  (cs_rise_o)
);

// File: tb/sim_qspi_frame_seq.sv
`timescale 1ns/1ps
module sim_qspi_frame_seq;
  localparam int HALF = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic start_i = 0, last_xfer_i = 0, tx_valid_i = 0, rx_ready_i = 0;
  logic [7:0] inst_code_i = 0, opt_byte_i = 0, tx_data_i = 0;
  logic [31:0] addr_i = 0;
  logic [2:0] width_i = 0;
  logic inst_en_i = 0, addr_en_i = 0, opt_en_i = 0, data_en_i = 0, addr32_i = 0;
  logic [1:0] opt_len_i = 0, xfer_type_i = 0;
  logic [4:0] dummy_i = 0;
  logic [3:0] io_i = 0;
  logic tx_ready_o, rx_valid_o, cs_n_o, sclk_o, inst_end_o, cs_rise_o;
  logic [7:0] rx_data_o;
  logic [3:0] io_o, io_oe_o;

  qspi_frame_seq #(.HALF_DIV(HALF)) u0 (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  // beat-level reference model
  logic [3:0] exp_oe[$], exp_out[$], in_q[$];
  logic [7:0] tx_bytes[$], rx_bytes[$];
  int beat_idx = 0, hi_run = 0;
  bit prev_sclk = 0, cs_low_seen = 0;
  string cur_tag = "R2";

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lines(int ph); // ph 0 inst, 1 addr/opt, 2 data
    case (width_i)
      3'd1: return (ph == 2) ? 2 : 1;
      3'd2: return (ph == 2) ? 4 : 1;
      3'd3: return (ph == 0) ? 1 : 2;
      3'd4: return (ph == 0) ? 1 : 4;
      3'd5: return 2;
      3'd6: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [3:0] mask(int ln);
    return (ln == 1) ? 4'b0001 : (ln == 2) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic push_out(logic [31:0] v, int nbits, int ln);
    int beats = nbits / ln;
    if (beats == 0) beats = 1;
    for (int b = 0; b < beats; b++) begin
      exp_oe.push_back(mask(ln));
      exp_out.push_back((ln == 1) ? {3'b0, v[31]} : (ln == 2) ? {2'b0, v[31:30]} : v[31:28]);
      in_q.push_back(4'h0);
      v = v << ln;
    end
  endtask

  task automatic push_read(logic [7:0] v, int ln);
    for (int b = 0; b < 8 / ln; b++) begin
      exp_oe.push_back(4'h0);
      exp_out.push_back(4'h0);
      in_q.push_back((ln == 1) ? {2'b0, v[7], 1'b0} : (ln == 2) ? {2'b0, v[7:6]} : v[7:4]);
      v = v << ln;
    end
  endtask

  task automatic build_expect();
    exp_oe.delete(); exp_out.delete(); in_q.delete();
    beat_idx = 0; cs_low_seen = 0;
    if (inst_en_i) push_out({inst_code_i, 24'h0}, 8, lines(0));
    if (addr_en_i) push_out(addr32_i ? addr_i : {addr_i[23:0], 8'h0}, addr32_i ? 32 : 24, lines(1));
    if (opt_en_i) push_out({opt_byte_i, 24'h0}, 1 << opt_len_i, lines(1));
    for (int d = 0; d < int'(dummy_i); d++) begin
      exp_oe.push_back(4'h0); exp_out.push_back(4'h0); in_q.push_back(4'h0);
    end
    if (data_en_i) begin
      if (xfer_type_i[1]) foreach (tx_bytes[i]) push_out({tx_bytes[i], 24'h0}, 8, lines(2));
      else foreach (rx_bytes[i]) push_read(rx_bytes[i], lines(2));
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    if (!cs_n_o) cs_low_seen = 1;
    if (cs_n_o) check("R1", "idle lines", {sclk_o, io_oe_o}, 5'h0);
    if (sclk_o && !prev_sclk) begin
      if (beat_idx >= exp_oe.size()) check(cur_tag, "extra beat", beat_idx, exp_oe.size());
      else begin
        check(cur_tag, "oe", io_oe_o, exp_oe[beat_idx]);
        check(cur_tag, "io", io_o & exp_oe[beat_idx], exp_out[beat_idx] & exp_oe[beat_idx]);
      end
      beat_idx++;
    end
    if (sclk_o) hi_run++;
    else if (prev_sclk) begin
      check("R10", "high half", hi_run, HALF);
      hi_run = 0;
    end
    if (!sclk_o && beat_idx < in_q.size()) io_i = in_q[beat_idx];
    prev_sclk = sclk_o;
  end

  task automatic wait_for(ref logic sig, input string tag);
    int g = 0;
    do begin @(negedge clk_i); g++; end while (!sig && g < 5000);
    if (!sig) check(tag, "handshake timeout", 0, 1);
  endtask

  task automatic run_frame(string tag, bit gap, bit last_with_valid, bit stray_last);
    cur_tag = tag;
    build_expect();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    if (data_en_i && xfer_type_i[1]) begin
      foreach (tx_bytes[i]) begin
        wait_for(tx_ready_o, "R9");
        tx_data_i = tx_bytes[i]; tx_valid_i = 1;
        @(negedge clk_i); tx_valid_i = 0;
        if (gap && i < tx_bytes.size() - 1) begin
          wait_for(tx_ready_o, "R9");
          repeat (8) begin
            @(negedge clk_i);
            check("R9", "cs held in gap", {cs_n_o, sclk_o}, 2'b00);
          end
        end
      end
      wait_for(tx_ready_o, "R9");
      last_xfer_i = 1;
      if (last_with_valid) begin
        tx_valid_i = 1; tx_data_i = 8'hEE;
        #1 check("R9", "ready with last", tx_ready_o, 0);
      end
      @(negedge clk_i); last_xfer_i = 0; tx_valid_i = 0;
    end else if (data_en_i) begin
      foreach (rx_bytes[i]) begin
        wait_for(rx_valid_o, "R7");
        check("R7", "rx byte", rx_data_o, rx_bytes[i]);
        rx_ready_i = 1; last_xfer_i = (i == rx_bytes.size() - 1);
        @(negedge clk_i); rx_ready_i = 0; last_xfer_i = 0;
      end
    end else if (stray_last) begin
      repeat (20) @(negedge clk_i);
      last_xfer_i = 1;
      @(negedge clk_i); last_xfer_i = 0;
    end
    if (!inst_end_o) wait_for(inst_end_o, "R8");
    check("R8", "cs at end", cs_n_o, 1);
    check("R8", "cs rise pulse", cs_rise_o, 1);
    check(tag, "beat count", beat_idx, exp_oe.size());
    @(negedge clk_i);
    check("R8", "pulse width", inst_end_o, 0);
  endtask

  task automatic setup(logic [2:0] w, bit ie, bit ae, bit oe, bit de, bit a32,
                       logic [1:0] ol, logic [4:0] dm, logic [1:0] ty);
    width_i = w; inst_en_i = ie; addr_en_i = ae; opt_en_i = oe; data_en_i = de;
    addr32_i = a32; opt_len_i = ol; dummy_i = dm; xfer_type_i = ty;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "reset outputs", {cs_n_o, sclk_o, io_oe_o, tx_ready_o, rx_valid_o, inst_end_o, cs_rise_o},
          {1'b1, 1'b0, 4'h0, 4'h0});

    // R3 R7: single line, instruction + read 2 bytes
    inst_code_i = 8'h9F; rx_bytes = '{8'hA5, 8'h3C}; tx_bytes = '{};
    setup(3'd0, 1, 0, 0, 1, 0, 2'd0, 5'd0, 2'd0);
    run_frame("R3", 0, 0, 0);

    // R4 R9: single line write, 24-bit address, gaps between bytes
    inst_code_i = 8'h02; addr_i = 32'hDE12_3456; tx_bytes = '{8'hC3, 8'h5A};
    setup(3'd0, 1, 1, 0, 1, 0, 2'd0, 5'd0, 2'd2);
    run_frame("R4", 1, 0, 0);

    // R4 R5 R6: quad IO memory read, 32-bit address, 8-bit option, dummy
    inst_code_i = 8'hEC; addr_i = 32'h8765_4321; opt_byte_i = 8'hA7; rx_bytes = '{8'h96, 8'h0F};
    setup(3'd4, 1, 1, 1, 1, 1, 2'd3, 5'd4, 2'd1);
    run_frame("R5", 0, 0, 0);

    // R5 R6: dual IO, 1-bit option on 2 lines, dummy 2
    inst_code_i = 8'hBB; addr_i = 32'h00F0_0F11; opt_byte_i = 8'h80; rx_bytes = '{8'h69};
    setup(3'd3, 1, 1, 1, 1, 0, 2'd0, 5'd2, 2'd0);
    run_frame("R6", 0, 0, 0);

    // R3 R9: all on 4 lines, memory write, last with valid ignored byte
    inst_code_i = 8'h38; addr_i = 32'h0012_ABCD; tx_bytes = '{8'h11, 8'hF0, 8'h7E};
    setup(3'd6, 1, 1, 0, 1, 0, 2'd0, 5'd0, 2'd3);
    run_frame("R3", 0, 1, 0);

    // R8: no data, all on 2 lines, stray last-transfer ignored
    inst_code_i = 8'hD8; addr_i = 32'h0034_5678; tx_bytes = '{}; rx_bytes = '{};
    setup(3'd5, 1, 1, 0, 0, 0, 2'd0, 5'd0, 2'd2);
    run_frame("R8", 0, 0, 1);

    // R2 R6: dual output read with 8 dummy clocks
    inst_code_i = 8'h3B; addr_i = 32'h00AB_CDEF; rx_bytes = '{8'hE1, 8'h2D};
    setup(3'd1, 1, 1, 0, 1, 0, 2'd0, 5'd8, 2'd1);
    run_frame("R2", 0, 0, 0);

    // R5 R7: quad output write, 2-bit option on 1 line, no instruction
    addr_i = 32'h0000_1000; opt_byte_i = 8'h40; tx_bytes = '{8'hB4, 8'h4B};
    setup(3'd2, 0, 1, 1, 1, 0, 2'd1, 5'd0, 2'd3);
    run_frame("R7", 0, 0, 0);

    // R8: nothing enabled, chip select never falls
    tx_bytes = '{}; rx_bytes = '{};
    setup(3'd0, 0, 0, 0, 0, 0, 2'd0, 5'd0, 2'd0);
    run_frame("R8", 0, 0, 0);
    check("R8", "cs never low", cs_low_seen, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule